// File: doc/BRIEF.md
# Cascadable Full Flag and Next-Free Locator

This block watches the per-entry empty bits of a small associative memory. It reports two things: whether the memory still has room, and which entry should be written next. The full indication is active low. It is meant to be daisy-chained vertically across identical devices: each device's full output feeds the full input of the device below it. The full output of the bottom device is then the full flag for the whole system. No central arbiter is needed to find the system's next free slot. That slot sits in the one device whose upstream full input is asserted (low) while its own full output is still high.

Each clock edge samples the empty vector and reduces it to a "has space" bit and the index of the lowest empty entry. Only those few bits are stored. The chain path itself is combinational, from full input to full output, so a change at the top of the chain reaches the bottom within the same cycle.

A control enable selects the flag function. When it is off, the device is a pass-through: its full output copies its full input, and it never claims the next free slot. The first device of a chain has its full input tied low.

Top module: `fc_full_chain`

## Requirements
- R1: While reset is high, and on the first cycle after it, every entry counts as empty. The free address is 0, and with the enable set the full output is high whatever the full input is.
- R2: With the enable set, full output is low exactly when full input is low and the most recently sampled empty vector is all zeros. Otherwise it is high.
- R3: With the enable clear, full output equals full input in the same cycle, local emptiness has no effect on it, and the owner output is 0.
- R4: The free address is the lowest bit index that is 1 in the sampled empty vector, where bit i = 1 means entry i is empty. It is 0 when no bit is set.
- R5: The owner output is 1 exactly when the enable is set, the full input is low and the sampled vector has at least one set bit.
- R6: The empty vector is sampled on the rising clock edge. A change in it reaches the outputs only after the next rising edge.
- R7: In a chain of devices, exactly one device asserts the owner output while any entry in the chain is empty. That device is the first one, counting from the top, that has space. The bottom full output goes low only when every device is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| empty_i | input | ENTRIES | Per-entry empty bits, 1 = empty |
| full_in_n | input | 1 | Active-low full from the device above; tie low on the first device |
| flag_en | input | 1 | 1 = flag function on, 0 = pass full input through |
| full_out_n | output | 1 | Active-low full to the device below |
| free_addr | output | AW | Lowest empty entry index |
| owns_free | output | 1 | This device holds the system's next free entry |

## Verification
Three instances are chained, and one vector walk moves the free space between them. The patterns are: all devices full; space only in the bottom device; space only in the middle device; space only at the top; space in several devices at once; single set bits at both ends of a vector. Together these show the owner passing to the first device with room, the bottom full flag rising and falling, and the encoder choosing the lowest set bit rather than the highest. Further vectors clear the enable with the upper devices holding space, to show that the bypass ignores local emptiness. Directed cases cover the reset state, a mixed enable along the chain, and the one-edge sampling delay.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // Address width for an entry count, never less than one bit.
  function automatic int addr_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fc_prio_enc.sv
module fc_prio_enc #(
  parameter int N  = 16,
  parameter int AW = fc_pkg::addr_w(N)
) (
  input  logic [N-1:0]  vec,
  output logic [AW-1:0] addr,
  output logic          any
);
  logic [N:0]   seen;
  logic [N-1:0] hit;

  assign seen[0] = 1'b0;

  // Thermometer of "a lower bit was already set"; the first set bit wins.
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    assign seen[gi+1] = seen[gi] | vec[gi];
    assign hit[gi]    = vec[gi] & ~seen[gi];
  end

  always_comb begin
    addr = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) addr = addr | AW'(i);
    end
  end

  assign any = seen[N];
endmodule

// File: rtl/fc_state_reg.sv
module fc_state_reg #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_d,
  input  logic          any_d,
  output logic [AW-1:0] addr_q,
  output logic          any_q
);
  // Reset value stands for "every entry empty": lowest free index is 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      any_q  <= 1'b1;
    end else begin
      addr_q <= addr_d;
      any_q  <= any_d;
    end
  end
endmodule

// File: rtl/fc_chain_out.sv
module fc_chain_out (
  input  logic flag_en,
  input  logic full_in_n,
  input  logic has_space,
  output logic full_out_n,
  output logic owns_free
);
  always_comb begin
    if (flag_en) begin
      full_out_n = full_in_n | has_space;
      owns_free  = ~full_in_n & has_space;
    end else begin
      full_out_n = full_in_n;
      owns_free  = 1'b0;
    end
  end
endmodule

// File: rtl/fc_full_chain.sv
module fc_full_chain #(
  parameter int ENTRIES = 16,
  localparam int AW     = fc_pkg::addr_w(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] empty_i,
  input  logic               full_in_n,
  input  logic               flag_en,
  output logic               full_out_n,
  output logic [AW-1:0]      free_addr,
  output logic               owns_free
);
  logic [AW-1:0] enc_addr;
  logic          enc_any;
  logic          space_q;

  fc_prio_enc #(.N(ENTRIES), .AW(AW)) u_enc (
    .vec  (empty_i),
    .addr (enc_addr),
    .any  (enc_any)
  );

  fc_state_reg #(.AW(AW)) u_state (
    .clk    (clk),
    .rst    (rst),
    .addr_d (enc_addr),
    .any_d  (enc_any),
    .addr_q (free_addr),
    .any_q  (space_q)
  );

  fc_chain_out u_out (
    .flag_en    (flag_en),
    .full_in_n  (full_in_n),
    .has_space  (space_q),
    .full_out_n (full_out_n),
    .owns_free  (owns_free)
  );
endmodule

// File: rtl/fc_full_chain_chk.sv
module fc_full_chain_chk #(
  parameter int ENTRIES = 16,
  localparam int AW     = fc_pkg::addr_w(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic [ENTRIES-1:0] empty_i,
  input logic               full_in_n,
  input logic               flag_en,
  input logic               full_out_n,
  input logic [AW-1:0]      free_addr,
  input logic               owns_free
);
  logic               past_valid = 1'b0;
  logic [ENTRIES-1:0] ref_vec;
  logic [ENTRIES-1:0] below_mask;

  always_ff @(posedge clk) begin
    past_valid <= 1'b1;
    if (rst) ref_vec <= '1;
    else     ref_vec <= empty_i;
  end

  always_comb below_mask = (ENTRIES'(1) << free_addr) - ENTRIES'(1);

  AST_RESET_STATE: assert property (@(posedge clk)
    past_valid && $past(rst) |-> (free_addr == '0) && (!flag_en || full_out_n)); // R1

  AST_FULL_NEEDS_UPSTREAM: assert property (@(posedge clk) disable iff (rst)
    flag_en && !full_out_n |-> !full_in_n); // R2

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !flag_en |-> (full_out_n == full_in_n) && !owns_free); // R3

  AST_ADDR_LOWEST: assert property (@(posedge clk) disable iff (rst)
    past_valid |-> (ref_vec == '0) ? (free_addr == '0)
                   : (ref_vec[free_addr] && ((ref_vec & below_mask) == '0))); // R4

  AST_OWNER_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    owns_free |-> flag_en && !full_in_n && full_out_n); // R5
endmodule

bind fc_full_chain fc_full_chain_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/fc_full_chain_test.sv
`timescale 1ns/1ps
module fc_full_chain_test;
  localparam int N = 8;
  localparam int AW = fc_pkg::addr_w(N);
  localparam int NV = 10;

  // {top vec, mid vec, bottom vec, enable, exp bottom full_n, exp owner (3 = none), exp addr}
  localparam logic [30:0] TBL [NV] = '{
    {8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 2'd3, 3'd0},
    {8'h00, 8'h00, 8'h80, 1'b1, 1'b1, 2'd2, 3'd7},
    {8'h00, 8'h0C, 8'hFF, 1'b1, 1'b1, 2'd1, 3'd2},
    {8'h01, 8'h00, 8'h00, 1'b1, 1'b1, 2'd0, 3'd0},
    {8'hA0, 8'h10, 8'h00, 1'b1, 1'b1, 2'd0, 3'd5},
    {8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 2'd3, 3'd0},
    {8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 2'd3, 3'd0},
    {8'h40, 8'h00, 8'h00, 1'b1, 1'b1, 2'd0, 3'd6},
    {8'h00, 8'h00, 8'h01, 1'b1, 1'b1, 2'd2, 3'd0},
    {8'h00, 8'h80, 8'h00, 1'b1, 1'b1, 2'd1, 3'd7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] e0 = '0, e1 = '0, e2 = '0;
  logic en0 = 1'b1, en1 = 1'b1, en2 = 1'b1;
  logic f0, f1, f2, o0, o1, o2;
  logic [AW-1:0] a0, a1, a2;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fc_full_chain #(.ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .empty_i(e0), .full_in_n(1'b0), .flag_en(en0),
    .full_out_n(f0), .free_addr(a0), .owns_free(o0));
  fc_full_chain #(.ENTRIES(N)) uut_b (
    .clk(clk), .rst(rst), .empty_i(e1), .full_in_n(f0), .flag_en(en1),
    .full_out_n(f1), .free_addr(a1), .owns_free(o1));
  fc_full_chain #(.ENTRIES(N)) uut_c (
    .clk(clk), .rst(rst), .empty_i(e2), .full_in_n(f1), .flag_en(en2),
    .full_out_n(f2), .free_addr(a2), .owns_free(o2));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int owner_idx();
    if ($countones({o2, o1, o0}) != 1) return 3;
    return o0 ? 0 : (o1 ? 1 : 2);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, all empty regardless of inputs
    @(negedge clk);
    step();
    chk("R1 top full_n in reset", int'(f0), 1);
    chk("R1 bottom full_n in reset", int'(f2), 1);
    chk("R1 top addr in reset", int'(a0), 0);
    chk("R1 top owns in reset", int'(o0), 1);
    chk("R1 owner count in reset", $countones({o2, o1, o0}), 1);
    rst = 1'b0;
    // first edge after release still shows the reset state
    chk("R1 bottom addr after release", int'(a2), 0);

    // Vector walk: R2 R4 R5 R7 (enabled rows), R3 (disabled rows)
    for (int v = 0; v < NV; v++) begin
      {e0, e1, e2, en0, en1, en2} = {TBL[v][30:23], TBL[v][22:15], TBL[v][14:7],
                                    TBL[v][6], TBL[v][6], TBL[v][6]};
      step();
      chk($sformatf("R2/R7 row %0d bottom full_n", v), int'(f2), int'(TBL[v][5]));
      chk($sformatf("R5/R7 row %0d owner", v), owner_idx(), int'(TBL[v][4:3]));
      case (TBL[v][4:3])
        2'd0, 2'd3: chk($sformatf("R4 row %0d addr", v), int'(a0), int'(TBL[v][2:0]));
        2'd1:       chk($sformatf("R4 row %0d addr", v), int'(a1), int'(TBL[v][2:0]));
        default:    chk($sformatf("R4 row %0d addr", v), int'(a2), int'(TBL[v][2:0]));
      endcase
      if (!TBL[v][6]) chk($sformatf("R3 row %0d top follows", v), int'(f0), 0);
    end

    // R3: middle bypassed while full; its output follows a high upstream
    e0 = 8'h02; e1 = 8'h00; e2 = 8'h00; en0 = 1'b1; en1 = 1'b0; en2 = 1'b1;
    step();
    chk("R3 mid follows high input", int'(f1), 1);
    chk("R3 mid owns off", int'(o1), 0);
    chk("R5 top owns", int'(o0), 1);
    // R3: bypassed middle with space does not hide a full upstream
    e0 = 8'h00; e1 = 8'hFF; e2 = 8'h00;
    step();
    chk("R3 mid ignores local space", int'(f1), 0);
    chk("R2 bottom full when all enabled blocks full", int'(f2), 0);
    chk("R3 mid owner off with space", int'(o1), 0);

    // R6: sampling delay
    en1 = 1'b1; e1 = 8'h00;
    step();
    chk("R6 setup all full", int'(f2), 0);
    e2 = 8'h10;
    #1;
    chk("R6 before edge unchanged", int'(f2), 0);
    step();
    chk("R6 after edge has space", int'(f2), 1);
    chk("R4 bottom addr", int'(a2), 4);
    chk("R7 bottom owns", owner_idx(), 2);

    // R4: highest index alone
    e0 = 8'h80;
    step();
    chk("R4 top addr msb", int'(a0), 7);
    chk("R7 owner moves to top", owner_idx(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule